// File: doc/BRIEF.md
# Per-Warp Memory Fence Ordering Queue

This block sits between a GPU core's memory dispatch stage and a cache hierarchy that is free to complete requests in any order. Each warp has its own in-order queue of memory requests: loads, stores, atomics, fences, and barrier-synchronise operations. Accesses leave the queues through a single downstream issue port. The block counts the accesses of each warp that are still outstanding. Completions come back on a response port and carry the warp number.

A fence at the head of a warp's queue holds that warp until every earlier access of the same warp has been acknowledged. The fence then retires, and the entries behind it continue in queue order. Other warps keep issuing while one warp waits. Each fence carries a visibility scope through to the point where it retires. The rule for retiring is the same for every scope, because an acknowledged store is already visible at the level the fence needs. A barrier operation becomes a block-scope fence. A fence or barrier whose lane mask is all zero is accepted and then dropped.

Enqueue and issue both use valid/ready. `enq_ready` is low whenever the queue of the warp named by `enq_warp` is full, and a request offered while `enq_ready` is low is not stored. `iss_valid` does not depend on `iss_ready`. Once offered, a request and its warp stay unchanged until they are accepted.

Top module: `warp_fence_lsq`

## Requirements
- R1: Requests of one warp leave on the issue port in the order they were enqueued, with op, address and lane mask unchanged.
- R2: Each warp queue holds 8 entries. `warp_full[w]` is high exactly when warp w holds 8 entries, and `enq_ready` is the inverse of the full flag of the warp named by `enq_warp`. A request offered while `enq_ready` is low is not stored.
- R3: A fence (op 3) or barrier (op 4) with an all-zero lane mask is accepted and discarded. It never blocks its warp and never produces `fence_done`.
- R4: While a fence is at the head of a warp's queue and that warp has an access still outstanding, that warp issues nothing.
- R5: A fence retires in the cycle it is at the head with zero outstanding accesses. `fence_done[w]` pulses for that cycle, and the entry behind the fence may issue from the next cycle. A fence is never sent downstream, so `iss_op` is always 0, 1 or 2.
- R6: A barrier operation (op 4) retires as a fence with block scope (scope 0), whatever its scope input was.
- R7: Scope codes are 0 for block, 1 for device and 2 for system. `fence_done_scope[2w+1:2w]` shows the retiring fence's scope while `fence_done[w]` is high, and reads 0 otherwise.
- R8: A fence waiting in one warp does not stop any other warp from issuing.
- R9: Issue grants go round-robin. After warp w is accepted, the search for the next grant starts at warp w+1, wrapping around.
- R10: While `iss_valid` is high and `iss_ready` is low, the next cycle keeps `iss_valid` high with the same warp, op, address and mask.
- R11: A warp with 15 accesses outstanding issues nothing until a response for it arrives.
- R12: After reset all queues are empty, no access is outstanding, and `iss_valid`, `warp_full` and `fence_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Dispatch offers a request |
| enq_ready | output | 1 | Queue of the addressed warp has room |
| enq_warp | input | 2 | Warp number of the offered request |
| enq_op | input | 3 | 0 load, 1 store, 2 atomic, 3 fence, 4 barrier |
| enq_scope | input | 2 | Fence scope: 0 block, 1 device, 2 system |
| enq_addr | input | 32 | Access address |
| enq_mask | input | 32 | Active lane mask |
| warp_full | output | 4 | Per-warp queue full flags |
| iss_valid | output | 1 | An access is offered downstream |
| iss_ready | input | 1 | Downstream accepts the offered access |
| iss_warp | output | 2 | Warp of the offered access |
| iss_op | output | 3 | Op of the offered access |
| iss_addr | output | 32 | Address of the offered access |
| iss_mask | output | 32 | Lane mask of the offered access |
| rsp_valid | input | 1 | An access has completed |
| rsp_warp | input | 2 | Warp of the completed access |
| fence_done | output | 4 | Per-warp fence retirement pulse |
| fence_done_scope | output | 8 | Per-warp scope of the retiring fence |

## Verification
The assertions assume that a response never names a warp with no outstanding access. A response that arrives in the same cycle as that warp's first issue also counts as a violation. The bench's reference model holds its own outstanding count per warp, and the stimulus only raises `rsp_valid` for warps whose count was nonzero before the current cycle. Downstream ready is driven at random and may drop while a request is offered, which exercises the hold rule. Fences, zero-mask fences and barriers are mixed with accesses across all four warps.

// File: rtl/wfq_pkg.sv
package wfq_pkg;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_ATOMIC  = 3'd2,
    OP_FENCE   = 3'd3,
    OP_BARRIER = 3'd4
  } wfq_op_e;

  typedef enum logic [1:0] {
    SCOPE_BLOCK  = 2'd0,
    SCOPE_DEVICE = 2'd1,
    SCOPE_SYSTEM = 2'd2
  } wfq_scope_e;

  // Ordering operations wait at the head and are never issued.
  function automatic logic is_order_op(input logic [2:0] op);
    return (op == OP_FENCE) || (op == OP_BARRIER);
  endfunction

endpackage

// File: rtl/wfq_warp_fifo.sv
module wfq_warp_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    rd_q, wr_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == LIMIT);
endmodule

// File: rtl/wfq_out_counter.sv
module wfq_out_counter #(
  parameter int MAX_OUT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic is_zero,
  output logic at_max
);
  localparam int CW = $clog2(MAX_OUT + 1);
  localparam logic [CW-1:0] TOP = CW'(MAX_OUT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign is_zero = (cnt_q == '0);
  assign at_max  = (cnt_q == TOP);
endmodule

// File: rtl/wfq_rr_arbiter.sv
module wfq_rr_arbiter #(
  parameter int N = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          accept,
  output logic          gnt_valid,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] gnt_idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW:0]   NW   = (IW + 1)'(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic          lock_q;
  logic [IW-1:0] lock_idx_q;
  logic [IW-1:0] ptr_q;
  logic          pick_v;
  logic [IW-1:0] pick_i;
  logic [IW:0]   cand;

  // Search from ptr_q upward with wrap; the lowest offset wins.
  always_comb begin
    pick_v = 1'b0;
    pick_i = '0;
    cand   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      cand = {1'b0, ptr_q} + (IW + 1)'(k);
      if (cand >= NW) cand = cand - NW;
      if (req[cand[IW-1:0]]) begin
        pick_v = 1'b1;
        pick_i = cand[IW-1:0];
      end
    end
  end

  assign gnt_valid = lock_q | pick_v;
  assign gnt_idx   = lock_q ? lock_idx_q : pick_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
      ptr_q      <= '0;
    end else begin
      lock_q     <= gnt_valid & ~accept;
      lock_idx_q <= gnt_idx;
      if (gnt_valid && accept)
        ptr_q <= (gnt_idx == LAST) ? '0 : gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/warp_fence_lsq.sv
module warp_fence_lsq
  import wfq_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int QDEPTH    = 8,
  parameter int ADDR_W    = 32,
  parameter int LANES     = 32,
  parameter int MAX_OUT   = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enq_valid,
  output logic                  enq_ready,
  input  logic [((NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1)-1:0] enq_warp,
  input  logic [2:0]            enq_op,
  input  logic [1:0]            enq_scope,
  input  logic [ADDR_W-1:0]     enq_addr,
  input  logic [LANES-1:0]      enq_mask,
  output logic [NUM_WARPS-1:0]  warp_full,
  output logic                  iss_valid,
  input  logic                  iss_ready,
  output logic [((NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1)-1:0] iss_warp,
  output logic [2:0]            iss_op,
  output logic [ADDR_W-1:0]     iss_addr,
  output logic [LANES-1:0]      iss_mask,
  input  logic                  rsp_valid,
  input  logic [((NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1)-1:0] rsp_warp,
  output logic [NUM_WARPS-1:0]  fence_done,
  output logic [2*NUM_WARPS-1:0] fence_done_scope
);
  localparam int WID_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1;
  localparam int ENT_W   = 5 + ADDR_W + LANES;
  localparam int OP_HI   = ENT_W - 1;
  localparam int SC_HI   = ENT_W - 4;

  logic              enq_is_order;
  logic              enq_drop;
  logic [2:0]        store_op;
  logic [1:0]        store_scope;
  logic [ENT_W-1:0]  enq_entry;
  logic              fire;
  logic              gnt_valid;
  logic [WID_W-1:0]  gnt_idx;
  logic [NUM_WARPS-1:0] req;
  logic [ENT_W-1:0]  head_arr [NUM_WARPS];
  logic [ENT_W-1:0]  sel;

  // Request conversion: barriers become block-scope fences; empty fences vanish.
  assign enq_is_order = is_order_op(enq_op);
  assign enq_drop     = enq_is_order && (enq_mask == '0);
  assign store_op     = enq_is_order ? OP_FENCE : enq_op;
  assign store_scope  = (enq_op == OP_BARRIER) ? SCOPE_BLOCK : enq_scope;
  assign enq_entry    = {store_op, store_scope, enq_addr, enq_mask};
  assign enq_ready    = ~warp_full[enq_warp];

  assign fire = gnt_valid & iss_ready;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic             push_w;
    logic             pop_w;
    logic             empty_w;
    logic             zero_w;
    logic             max_w;
    logic             head_order;
    logic             sel_w;
    logic [ENT_W-1:0] head_w;

    assign sel_w  = fire && (gnt_idx == WID_W'(w));
    assign push_w = enq_valid && enq_ready && !enq_drop && (enq_warp == WID_W'(w));

    wfq_warp_fifo #(.DEPTH(QDEPTH), .WIDTH(ENT_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_w),
      .din   (enq_entry),
      .pop   (pop_w),
      .dout  (head_w),
      .empty (empty_w),
      .full  (warp_full[w])
    );

    wfq_out_counter #(.MAX_OUT(MAX_OUT)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (sel_w),
      .dec     (rsp_valid && (rsp_warp == WID_W'(w))),
      .is_zero (zero_w),
      .at_max  (max_w)
    );

    assign head_order    = is_order_op(head_w[OP_HI -: 3]);
    assign fence_done[w] = !empty_w && head_order && zero_w;
    assign req[w]        = !empty_w && !head_order && !max_w;
    assign pop_w         = fence_done[w] | sel_w;
    assign head_arr[w]   = head_w;
    assign fence_done_scope[2*w +: 2] = fence_done[w] ? head_w[SC_HI -: 2] : 2'b00;
  end

  wfq_rr_arbiter #(.N(NUM_WARPS)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .accept    (iss_ready),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  assign sel       = head_arr[gnt_idx];
  assign iss_valid = gnt_valid;
  assign iss_warp  = gnt_idx;
  assign iss_op    = sel[OP_HI -: 3];
  assign iss_addr  = sel[LANES +: ADDR_W];
  assign iss_mask  = sel[LANES-1:0];
endmodule

// File: rtl/wfq_checker.sv
module wfq_checker #(
  parameter int NUM_WARPS = 4,
  parameter int ADDR_W    = 32,
  parameter int LANES     = 32,
  parameter int MAX_OUT   = 15
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  iss_valid,
  input logic                  iss_ready,
  input logic [((NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1)-1:0] iss_warp,
  input logic [2:0]            iss_op,
  input logic [ADDR_W-1:0]     iss_addr,
  input logic [LANES-1:0]      iss_mask,
  input logic                  rsp_valid,
  input logic [((NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1)-1:0] rsp_warp,
  input logic [NUM_WARPS-1:0]  fence_done,
  input logic [2*NUM_WARPS-1:0] fence_done_scope
);
  localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1;
  localparam int CW    = $clog2(MAX_OUT + 2);

  logic [CW-1:0] seen_out [NUM_WARPS];

  // Outstanding count rebuilt from the issue and response ports.
  always_ff @(posedge clk) begin
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (!rst_n) begin
        seen_out[w] <= '0;
      end else begin
        seen_out[w] <= seen_out[w]
                       + CW'(iss_valid && iss_ready && (iss_warp == WID_W'(w)))
                       - CW'(rsp_valid && (rsp_warp == WID_W'(w)));
      end
    end
  end

  // Input rule: a response names a warp that has an access outstanding.
  rsp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> seen_out[rsp_warp] != '0);

  // R10
  iss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_warp) && $stable(iss_op)
                                   && $stable(iss_addr) && $stable(iss_mask)));

  // R5
  no_fence_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_op <= 3'd2));

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_chk
    // R4
    fence_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fence_done[w] |-> seen_out[w] == '0);

    // R11
    out_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_warp == WID_W'(w)) |-> seen_out[w] < CW'(MAX_OUT));

    // R7
    scope_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fence_done[w] |-> fence_done_scope[2*w +: 2] != 2'b11);

    // R7
    scope_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fence_done[w] |-> fence_done_scope[2*w +: 2] == 2'b00);
  end
endmodule

bind warp_fence_lsq wfq_checker #(
  .NUM_WARPS (NUM_WARPS),
  .ADDR_W    (ADDR_W),
  .LANES     (LANES),
  .MAX_OUT   (MAX_OUT)
) u_wfq_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .iss_valid        (iss_valid),
  .iss_ready        (iss_ready),
  .iss_warp         (iss_warp),
  .iss_op           (iss_op),
  .iss_addr         (iss_addr),
  .iss_mask         (iss_mask),
  .rsp_valid        (rsp_valid),
  .rsp_warp         (rsp_warp),
  .fence_done       (fence_done),
  .fence_done_scope (fence_done_scope)
);

// File: tb/warp_fence_lsq_tb_top.sv
`timescale 1ns/1ps
module warp_fence_lsq_tb_top;
  localparam int NW   = 4;
  localparam int DEP  = 8;
  localparam int MAXO = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enq_valid = 1'b0;
  logic        enq_ready;
  logic [1:0]  enq_warp = '0;
  logic [2:0]  enq_op = '0;
  logic [1:0]  enq_scope = '0;
  logic [31:0] enq_addr = '0;
  logic [31:0] enq_mask = '0;
  logic [3:0]  warp_full;
  logic        iss_valid;
  logic        iss_ready = 1'b0;
  logic [1:0]  iss_warp;
  logic [2:0]  iss_op;
  logic [31:0] iss_addr;
  logic [31:0] iss_mask;
  logic        rsp_valid = 1'b0;
  logic [1:0]  rsp_warp = '0;
  logic [3:0]  fence_done;
  logic [7:0]  fence_done_scope;

  always #4 clk = ~clk;

  warp_fence_lsq dut_i (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_warp(enq_warp),
    .enq_op(enq_op), .enq_scope(enq_scope), .enq_addr(enq_addr), .enq_mask(enq_mask),
    .warp_full(warp_full),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_warp(iss_warp),
    .iss_op(iss_op), .iss_addr(iss_addr), .iss_mask(iss_mask),
    .rsp_valid(rsp_valid), .rsp_warp(rsp_warp),
    .fence_done(fence_done), .fence_done_scope(fence_done_scope)
  );

  // Reference model: entry = {op, scope, addr, mask}
  logic [68:0] mq [NW][$];
  int  m_out [NW];
  int  m_rr = 0;
  bit  m_lock = 0;
  int  m_lockw = 0;
  int  errors = 0;
  int  checks = 0;
  bit  finished = 0;
  int  fired_w [$];
  logic [31:0] fired_a [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Compare this cycle's outputs with the model, then advance the model.
  task automatic tick();
    bit ef [NW];
    bit fd [NW];
    bit el [NW];
    bit v;
    int g;
    logic [68:0] h;
    #1;
    for (int w = 0; w < NW; w++) begin
      ef[w] = (mq[w].size() == DEP);
      fd[w] = 0; el[w] = 0;
      if (mq[w].size() > 0) begin
        h = mq[w][0];
        fd[w] = (h[68:66] == 3'd3) && (m_out[w] == 0);
        el[w] = (h[68:66] != 3'd3) && (m_out[w] < MAXO);
      end
    end
    v = 0; g = 0;
    if (m_lock) begin v = 1; g = m_lockw; end
    else begin
      for (int k = 0; k < NW; k++) begin
        if (!v && el[(m_rr + k) % NW]) begin v = 1; g = (m_rr + k) % NW; end
      end
    end
    for (int w = 0; w < NW; w++) begin
      chk(warp_full[w] == ef[w], "R2", "warp_full", warp_full[w], ef[w]);
      chk(fence_done[w] == fd[w], "R5", "fence_done", fence_done[w], fd[w]);
      if (fd[w]) chk(fence_done_scope[2*w +: 2] == mq[w][0][65:64], "R7", "scope",
                     fence_done_scope[2*w +: 2], mq[w][0][65:64]);
    end
    chk(enq_ready == !ef[enq_warp], "R2", "enq_ready", enq_ready, !ef[enq_warp]);
    chk(iss_valid == v, "R9", "iss_valid", iss_valid, v);
    if (v && iss_valid) begin
      h = mq[g][0];
      chk(iss_warp == 2'(g), "R9", "iss_warp", iss_warp, g);
      chk({iss_op, iss_addr, iss_mask} == {h[68:66], h[63:0]}, "R1", "payload",
          {iss_op, iss_addr, iss_mask}, {h[68:66], h[63:0]});
    end
    // advance
    if (v && iss_ready) begin
      fired_w.push_back(g); fired_a.push_back(mq[g][0][63:32]);
      void'(mq[g].pop_front());
      m_out[g]++;
      m_rr = (g + 1) % NW;
      m_lock = 0;
    end else begin
      m_lock = v; m_lockw = g;
    end
    for (int w = 0; w < NW; w++) if (fd[w]) void'(mq[w].pop_front());
    if (rsp_valid) m_out[rsp_warp]--;
    if (enq_valid && !ef[enq_warp]) begin
      if (enq_op == 3'd3 || enq_op == 3'd4) begin
        if (enq_mask != 0)
          mq[enq_warp].push_back({3'd3, (enq_op == 3'd4) ? 2'd0 : enq_scope, enq_addr, enq_mask});
      end else begin
        mq[enq_warp].push_back({enq_op, enq_scope, enq_addr, enq_mask});
      end
    end
    @(negedge clk);
  endtask

  task automatic set_enq(input bit vld, input int w, input int op, input int sc,
                         input logic [31:0] a, input logic [31:0] m);
    enq_valid = vld; enq_warp = 2'(w); enq_op = 3'(op); enq_scope = 2'(sc);
    enq_addr = a; enq_mask = m;
  endtask

  task automatic pick_rsp(input int pct);
    int s;
    bit got;
    rsp_valid = 0;
    got = 0;
    s = $urandom_range(NW - 1);
    if ($urandom_range(99) < pct) begin
      for (int k = 0; k < NW; k++) begin
        if (!got && m_out[(s + k) % NW] > 0) begin
          got = 1; rsp_valid = 1; rsp_warp = 2'((s + k) % NW);
        end
      end
    end
  endtask

  task automatic drain();
    set_enq(0, 0, 0, 0, 0, 0);
    iss_ready = 1;
    for (int i = 0; i < 50; i++) begin
      pick_rsp(100);
      tick();
    end
    rsp_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog act=running exp=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int sent;
    int r;
    for (int w = 0; w < NW; w++) m_out[w] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(iss_valid == 0, "R12", "iss_valid", iss_valid, 0);
    chk(warp_full == 0, "R12", "warp_full", warp_full, 0);
    chk(fence_done == 0, "R12", "fence_done", fence_done, 0);
    chk(enq_ready == 1, "R12", "enq_ready", enq_ready, 1);
    @(negedge clk);
    rst_n = 1;

    // R4 R5 R8: fence in warp 0 waits for its store; warp 1 continues
    iss_ready = 1;
    set_enq(1, 0, 1, 0, 32'h100, '1); tick();
    set_enq(1, 0, 3, 2, 0, 32'hF);    tick();
    set_enq(1, 0, 0, 0, 32'h104, '1); tick();
    set_enq(1, 1, 0, 0, 32'h200, '1); tick();
    set_enq(0, 0, 0, 0, 0, 0);
    #1;
    chk(iss_valid && iss_warp == 1, "R8", "other warp issues", iss_warp, 1);
    chk(fence_done[0] == 0, "R4", "fence waits", fence_done[0], 0);
    tick(); tick();
    #1;
    chk(iss_valid == 0, "R4", "warp0 held", iss_valid, 0);
    rsp_valid = 1; rsp_warp = 0; tick(); rsp_valid = 0;
    #1;
    chk(fence_done[0] == 1, "R5", "fence retires", fence_done[0], 1);
    chk(fence_done_scope[1:0] == 2, "R7", "system scope", fence_done_scope[1:0], 2);
    tick();
    #1;
    chk(iss_valid && iss_warp == 0 && iss_addr == 32'h104, "R5", "resume", iss_addr, 32'h104);
    drain();

    // R3: zero-mask fence is dropped
    set_enq(1, 2, 1, 0, 32'h300, '1); tick();
    set_enq(1, 2, 3, 1, 0, 0);        tick();
    set_enq(1, 2, 0, 0, 32'h304, '1); tick();
    set_enq(0, 0, 0, 0, 0, 0);
    #1;
    chk(iss_valid && iss_warp == 2 && iss_addr == 32'h304, "R3", "load passes", iss_addr, 32'h304);
    chk(fence_done == 0, "R3", "no retire", fence_done, 0);
    drain();

    // R6: barrier retires with block scope
    set_enq(1, 3, 4, 2, 0, 32'h1); tick();
    set_enq(0, 0, 0, 0, 0, 0);
    #1;
    chk(fence_done[3] == 1, "R6", "barrier retires", fence_done[3], 1);
    chk(fence_done_scope[7:6] == 0, "R6", "barrier scope", fence_done_scope[7:6], 0);
    drain();

    // R2 R1: fill warp 1, reject the ninth, check order
    iss_ready = 0;
    for (int i = 0; i < 8; i++) begin
      set_enq(1, 1, 0, 0, 32'h400 + 32'(i * 4), '1); tick();
    end
    set_enq(1, 1, 0, 0, 32'h4FF, '1);
    #1;
    chk(warp_full[1] == 1, "R2", "full flag", warp_full[1], 1);
    chk(enq_ready == 0, "R2", "ready low", enq_ready, 0);
    tick();
    fired_w.delete(); fired_a.delete();
    drain();
    chk(fired_w.size() == 8, "R2", "ninth not stored", fired_w.size(), 8);
    for (int i = 0; i < 8 && i < fired_a.size(); i++)
      chk(fired_a[i] == 32'h400 + 32'(i * 4), "R1", "order", fired_a[i], 32'h400 + i * 4);

    // R11: outstanding limit
    iss_ready = 1; rsp_valid = 0; sent = 0;
    for (int i = 0; i < 200 && sent < 20; i++) begin
      set_enq(1, 1, 2, 0, 32'h500 + 32'(sent), '1);
      r = (warp_full[1] == 0) ? 1 : 0;
      tick();
      sent += r;
    end
    set_enq(0, 0, 0, 0, 0, 0);
    repeat (5) tick();
    #1;
    chk(iss_valid == 0, "R11", "limit holds issue", iss_valid, 0);
    drain();

    // R10 R9 random mix
    for (int c = 0; c < 4000; c++) begin
      r = $urandom_range(9);
      set_enq($urandom_range(99) < 60, $urandom_range(NW - 1),
              (r < 6) ? r % 3 : ((r < 8) ? 3 : 4), $urandom_range(2),
              $urandom, ($urandom_range(3) == 0) ? 32'h0 : $urandom);
      iss_ready = ($urandom_range(99) < 70);
      pick_rsp(45);
      tick();
    end
    drain();

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule